// File: doc/BRIEF.md
# Panel Initialization Serial Sequencer

This block brings an LCD controller up and down over a write-only three-wire serial link made of chip-select, serial clock and serial data. Software asks for one of four phases with a single-cycle pulse: power-up, display-on, display-off or power-down. The block then steps through a fixed table of steps. Each step is a register code followed by zero, one or two parameter bytes. A step may also ask for a pause after it is sent.

Every word on the link is nine bits long and is sent most significant bit first. The top bit tells the panel whether the word is a register code or a parameter. Chip-select stays low across a whole step and goes high between steps. At the end of each step the block samples an external link-error input. During power-up, display-on and display-off, an error stops the rest of the phase. During power-down the error is recorded and the remaining steps are still sent, so the panel always ends up powered down. Each phase ends with a completion pulse and a failure level.

Top module: `panel_seq_top`

## Requirements
- R1: While reset is held and after it is released, chip-select and serial clock are high, and busy, done, failed and start_ignored are all low.
- R2: Each word is 9 bits, sent most significant bit first. Bit 8 is 0 for a register-code word and 1 for a parameter word. Bits 7..0 carry the value.
- R3: The serial clock idles high. Data changes only on a falling clock edge and is stable across every rising edge. The serial clock is high whenever chip-select is high.
- R4: A step with a 16-bit parameter sends its code word and then two parameter words: high byte first, low byte second.
- R5: Power-up sends 43 steps in a fixed order. It opens with three bare 0x00 codes, then sends: 0xB0 with 0x17, 0xBC with 0x80, 0x3B with 0x00, 0xB0 with 0x16, 0xB8 with 0xFFF9, and the bare code 0x11. The register set-up list follows, ending with 0xD5 with 0x0E.
- R6: Display-on sends the single bare code 0x29. Display-off sends the single bare code 0x28.
- R7: Power-down sends three steps: 0xB8 with 0x8002, then the bare code 0x10, then 0xB0 with 0x00.
- R8: Chip-select is low from the first bit of a step's code word to the last bit of its final parameter word. It is high between steps for at least 4*HALF_DIV system cycles, which is two serial-clock periods.
- R9: After each of the three leading power-up codes, chip-select stays high for at least CYC_PER_US*PAUSE_US system cycles.
- R10: link_err is sampled in the cycle a step ends. If it is high during power-up, display-on or display-off, no further step of that phase is sent, and the phase completes with failed high.
- R11: During power-down, a link error does not stop the phase: all steps are still sent, and the phase completes with failed high. A later phase with no error completes with failed low.
- R12: A start pulse that arrives while busy is ignored. The sequence in progress is unchanged, and start_ignored pulses high for one cycle in the following cycle.
- R13: When several start pulses arrive together while idle, the order of precedence is power-up, then display-on, then display-off, then power-down.
- R14: busy rises the cycle after an accepted start. done pulses for one cycle in the first idle cycle after the last step's deselect interval, and busy is low while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_prepare | input | 1 | One-cycle request for the power-up phase |
| start_enable | input | 1 | One-cycle request for the display-on phase |
| start_disable | input | 1 | One-cycle request for the display-off phase |
| start_unprepare | input | 1 | One-cycle request for the power-down phase |
| link_err | input | 1 | Link fault, sampled at the end of each step |
| spi_csn | output | 1 | Active-low chip-select |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_sdo | output | 1 | Serial data out |
| busy | output | 1 | A phase is in progress |
| done | output | 1 | One-cycle phase-completion pulse |
| seq_failed | output | 1 | Failure result of the last completed phase |
| start_ignored | output | 1 | One-cycle pulse: a start arrived while busy |

## Verification
The bench sets HALF_DIV to 1, so each serial-clock half-period is a single system cycle. This makes every data change and every sampling edge visible cycle by cycle, and lets the full 43-step power-up run several times in a short simulation. It sets CYC_PER_US to 2 and PAUSE_US to 3. The resulting 6-cycle pause is longer than the 4-cycle deselect minimum, so the bench can tell the longer pause after the three leading codes apart from the ordinary gap between steps. Errors are injected on chosen step numbers, which exercises the abort path in the middle of power-up and the non-aborting path in power-down.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  localparam int STEP_AW  = 6;
  localparam int WORD_W   = 9;
  localparam int PREP_BASE = 0;
  localparam int EN_BASE   = 43;
  localparam int DIS_BASE  = 44;
  localparam int UNP_BASE  = 45;

  typedef enum logic [1:0] {
    PH_PREP = 2'd0,
    PH_EN   = 2'd1,
    PH_DIS  = 2'd2,
    PH_UNP  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [7:0]  code;
    logic [1:0]  nparm;
    logic [15:0] val;
    logic        pause;
    logic        last;
  } step_t;

  function automatic step_t mk(input logic [7:0] c, input logic [1:0] n,
                               input logic [15:0] v, input logic p,
                               input logic l);
    step_t s;
    s.code  = c;
    s.nparm = n;
    s.val   = v;
    s.pause = p;
    s.last  = l;
    return s;
  endfunction

endpackage

// File: rtl/panel_seq_rom.sv
module panel_seq_rom
  import panel_seq_pkg::*;
(
  input  logic [STEP_AW-1:0] idx_i,
  output step_t              step_o
);

  // Step table: power-up 0..42, display-on 43, display-off 44,
  // power-down 45..47. 'last' closes each phase.
  always_comb begin
    case (idx_i)
      6'd0:  step_o = mk(8'h00, 2'd0, 16'h0000, 1'b1, 1'b0);
      6'd1:  step_o = mk(8'h00, 2'd0, 16'h0000, 1'b1, 1'b0);
      6'd2:  step_o = mk(8'h00, 2'd0, 16'h0000, 1'b1, 1'b0);
      6'd3:  step_o = mk(8'hB0, 2'd1, 16'h0017, 1'b0, 1'b0);
      6'd4:  step_o = mk(8'hBC, 2'd1, 16'h0080, 1'b0, 1'b0);
      6'd5:  step_o = mk(8'h3B, 2'd1, 16'h0000, 1'b0, 1'b0);
      6'd6:  step_o = mk(8'hB0, 2'd1, 16'h0016, 1'b0, 1'b0);
      6'd7:  step_o = mk(8'hB8, 2'd2, 16'hFFF9, 1'b0, 1'b0);
      6'd8:  step_o = mk(8'h11, 2'd0, 16'h0000, 1'b0, 1'b0);
      6'd9:  step_o = mk(8'hBA, 2'd1, 16'h0001, 1'b0, 1'b0);
      6'd10: step_o = mk(8'hBB, 2'd1, 16'h0000, 1'b0, 1'b0);
      6'd11: step_o = mk(8'h3A, 2'd1, 16'h0060, 1'b0, 1'b0);
      6'd12: step_o = mk(8'hBF, 2'd1, 16'h0010, 1'b0, 1'b0);
      6'd13: step_o = mk(8'hB1, 2'd1, 16'h0056, 1'b0, 1'b0);
      6'd14: step_o = mk(8'hB2, 2'd1, 16'h0033, 1'b0, 1'b0);
      6'd15: step_o = mk(8'hB3, 2'd1, 16'h0011, 1'b0, 1'b0);
      6'd16: step_o = mk(8'hB3, 2'd1, 16'h0011, 1'b0, 1'b0);
      6'd17: step_o = mk(8'hB4, 2'd1, 16'h0002, 1'b0, 1'b0);
      6'd18: step_o = mk(8'hB5, 2'd1, 16'h002B, 1'b0, 1'b0);
      6'd19: step_o = mk(8'hB6, 2'd1, 16'h0040, 1'b0, 1'b0);
      6'd20: step_o = mk(8'hB7, 2'd1, 16'h0003, 1'b0, 1'b0);
      6'd21: step_o = mk(8'hB9, 2'd1, 16'h0004, 1'b0, 1'b0);
      6'd22: step_o = mk(8'hBD, 2'd1, 16'h0004, 1'b0, 1'b0);
      6'd23: step_o = mk(8'hBE, 2'd1, 16'h0000, 1'b0, 1'b0);
      6'd24: step_o = mk(8'hC0, 2'd1, 16'h0011, 1'b0, 1'b0);
      6'd25: step_o = mk(8'hC1, 2'd1, 16'h0011, 1'b0, 1'b0);
      6'd26: step_o = mk(8'hC2, 2'd1, 16'h0011, 1'b0, 1'b0);
      6'd27: step_o = mk(8'hC3, 2'd2, 16'h2040, 1'b0, 1'b0);
      6'd28: step_o = mk(8'hC4, 2'd2, 16'h60C0, 1'b0, 1'b0);
      6'd29: step_o = mk(8'hC5, 2'd2, 16'h1020, 1'b0, 1'b0);
      6'd30: step_o = mk(8'hC6, 2'd2, 16'h60C0, 1'b0, 1'b0);
      6'd31: step_o = mk(8'hC7, 2'd2, 16'h5533, 1'b0, 1'b0);
      6'd32: step_o = mk(8'hC8, 2'd1, 16'h0000, 1'b0, 1'b0);
      6'd33: step_o = mk(8'hC9, 2'd1, 16'h0000, 1'b0, 1'b0);
      6'd34: step_o = mk(8'hCA, 2'd1, 16'h0000, 1'b0, 1'b0);
      6'd35: step_o = mk(8'hEC, 2'd2, 16'h01F0, 1'b0, 1'b0);
      6'd36: step_o = mk(8'hCF, 2'd1, 16'h0002, 1'b0, 1'b0);
      6'd37: step_o = mk(8'hD0, 2'd2, 16'h0804, 1'b0, 1'b0);
      6'd38: step_o = mk(8'hD1, 2'd1, 16'h0001, 1'b0, 1'b0);
      6'd39: step_o = mk(8'hD2, 2'd2, 16'h0000, 1'b0, 1'b0);
      6'd40: step_o = mk(8'hD3, 2'd2, 16'h0D0E, 1'b0, 1'b0);
      6'd41: step_o = mk(8'hD4, 2'd2, 16'h11A4, 1'b0, 1'b0);
      6'd42: step_o = mk(8'hD5, 2'd1, 16'h000E, 1'b0, 1'b1);
      6'd43: step_o = mk(8'h29, 2'd0, 16'h0000, 1'b0, 1'b1);
      6'd44: step_o = mk(8'h28, 2'd0, 16'h0000, 1'b0, 1'b1);
      6'd45: step_o = mk(8'hB8, 2'd2, 16'h8002, 1'b0, 1'b0);
      6'd46: step_o = mk(8'h10, 2'd0, 16'h0000, 1'b0, 1'b0);
      6'd47: step_o = mk(8'hB0, 2'd1, 16'h0000, 1'b0, 1'b1);
      default: step_o = mk(8'h00, 2'd0, 16'h0000, 1'b0, 1'b1);
    endcase
  end

endmodule

// File: rtl/panel_seq_shift.sv
module panel_seq_shift #(
  parameter int HALF_DIV = 4,
  parameter int WORD_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              sclk_o,
  output logic              sdo_o,
  output logic              fin_o
);

  // One setup half-period, then a low and a high half per bit.
  localparam int HP_TOT  = 2 * WORD_W + 1;
  localparam int HP_LAST = HP_TOT - 1;
  localparam int HPW     = $clog2(HP_TOT + 1);
  localparam int DIVW    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic              act_q, act_d;
  logic [HPW-1:0]    hp_q, hp_d;
  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic              sclk_q, sclk_d;
  logic              sdo_q, sdo_d;
  logic              fin_q, fin_d;
  logic              tick;

  generate
    if (HALF_DIV == 1) begin : g_nodiv
      assign tick = act_q;
    end else begin : g_div
      logic [DIVW-1:0] div_q, div_d;
      always_comb begin
        div_d = div_q;
        if (!act_q || tick) div_d = '0;
        else                div_d = div_q + DIVW'(1);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end
      assign tick = act_q && (div_q == DIVW'(HALF_DIV - 1));
    end
  endgenerate

  always_comb begin
    act_d  = act_q;
    hp_d   = hp_q;
    sreg_d = sreg_q;
    sclk_d = sclk_q;
    sdo_d  = sdo_q;
    fin_d  = 1'b0;
    if (!act_q) begin
      sclk_d = 1'b1;
      if (go_i) begin
        act_d  = 1'b1;
        hp_d   = '0;
        sreg_d = word_i;
        sdo_d  = word_i[WORD_W-1];
      end
    end else if (tick) begin
      if (hp_q == HPW'(HP_LAST)) begin
        act_d  = 1'b0;
        fin_d  = 1'b1;
        sclk_d = 1'b1;
      end else begin
        hp_d = hp_q + HPW'(1);
        if (!hp_q[0]) begin
          sclk_d = 1'b0;
          if (hp_q != '0) begin
            sreg_d = {sreg_q[WORD_W-2:0], 1'b0};
            sdo_d  = sreg_q[WORD_W-2];
          end
        end else begin
          sclk_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      hp_q   <= '0;
      sreg_q <= '0;
      sclk_q <= 1'b1;
      sdo_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      hp_q   <= hp_d;
      sreg_q <= sreg_d;
      sclk_q <= sclk_d;
      sdo_q  <= sdo_d;
      fin_q  <= fin_d;
    end
  end

  assign sclk_o = sclk_q;
  assign sdo_o  = sdo_q;
  assign fin_o  = fin_q;

  // R3: data never moves on a sampling edge.
  p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(sdo_q));
  // R3: clock rests high between words.
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !$past(act_q)) |-> sclk_q);

endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
  import panel_seq_pkg::*;
#(
  parameter int GAP_CYC   = 16,
  parameter int PAUSE_CYC = 50000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         req_i,
  input  logic               link_err_i,
  input  step_t              step_i,
  input  logic               fin_i,
  output logic [STEP_AW-1:0] idx_o,
  output logic               go_o,
  output logic [WORD_W-1:0]  word_o,
  output logic               csn_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               failed_o,
  output logic               ign_o
);

  localparam int SPAN = (PAUSE_CYC > GAP_CYC) ? PAUSE_CYC : GAP_CYC;
  localparam int CNTW = $clog2(SPAN + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_XMIT, S_ENDE, S_GAP
  } st_e;

  st_e                st_q, st_d;
  phase_e             ph_q, ph_d;
  logic [STEP_AW-1:0] idx_q, idx_d;
  logic [1:0]         wsel_q, wsel_d;
  logic [CNTW-1:0]    cnt_q, cnt_d;
  logic               err_q, err_d;
  logic               abort_q, abort_d;
  logic               csn_q, csn_d;
  logic               done_q, done_d;
  logic               failed_q, failed_d;
  logic               ign_q, ign_d;
  logic [7:0]         pbyte;

  assign pbyte = (step_i.nparm == 2'd2 && wsel_q == 2'd0) ? step_i.val[15:8]
                                                          : step_i.val[7:0];

  always_comb begin
    st_d     = st_q;
    ph_d     = ph_q;
    idx_d    = idx_q;
    wsel_d   = wsel_q;
    cnt_d    = cnt_q;
    err_d    = err_q;
    abort_d  = abort_q;
    csn_d    = csn_q;
    done_d   = 1'b0;
    failed_d = failed_q;
    ign_d    = (st_q != S_IDLE) && (|req_i);
    go_o     = 1'b0;
    word_o   = {1'b0, step_i.code};
    case (st_q)
      S_IDLE: begin
        if (|req_i) begin
          err_d   = 1'b0;
          abort_d = 1'b0;
          st_d    = S_FETCH;
          if (req_i[0]) begin
            ph_d = PH_PREP; idx_d = STEP_AW'(PREP_BASE);
          end else if (req_i[1]) begin
            ph_d = PH_EN;   idx_d = STEP_AW'(EN_BASE);
          end else if (req_i[2]) begin
            ph_d = PH_DIS;  idx_d = STEP_AW'(DIS_BASE);
          end else begin
            ph_d = PH_UNP;  idx_d = STEP_AW'(UNP_BASE);
          end
        end
      end
      S_FETCH: begin
        csn_d  = 1'b0;
        wsel_d = 2'd0;
        go_o   = 1'b1;
        st_d   = S_XMIT;
      end
      S_XMIT: begin
        if (fin_i) begin
          if (wsel_q < step_i.nparm) begin
            go_o   = 1'b1;
            word_o = {1'b1, pbyte};
            wsel_d = wsel_q + 2'd1;
          end else begin
            st_d = S_ENDE;
          end
        end
      end
      S_ENDE: begin
        csn_d = 1'b1;
        if (link_err_i) begin
          err_d = 1'b1;
          if (ph_q != PH_UNP) abort_d = 1'b1;
        end
        cnt_d = step_i.pause ? CNTW'(SPAN - 1) : CNTW'(GAP_CYC - 1);
        st_d  = S_GAP;
      end
      S_GAP: begin
        if (cnt_q == '0) begin
          if (step_i.last || abort_q) begin
            st_d     = S_IDLE;
            done_d   = 1'b1;
            failed_d = err_q;
          end else begin
            idx_d = idx_q + STEP_AW'(1);
            st_d  = S_FETCH;
          end
        end else begin
          cnt_d = cnt_q - CNTW'(1);
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      ph_q     <= PH_PREP;
      idx_q    <= '0;
      wsel_q   <= '0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
      abort_q  <= 1'b0;
      csn_q    <= 1'b1;
      done_q   <= 1'b0;
      failed_q <= 1'b0;
      ign_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      ph_q     <= ph_d;
      idx_q    <= idx_d;
      wsel_q   <= wsel_d;
      cnt_q    <= cnt_d;
      err_q    <= err_d;
      abort_q  <= abort_d;
      csn_q    <= csn_d;
      done_q   <= done_d;
      failed_q <= failed_d;
      ign_q    <= ign_d;
    end
  end

  assign idx_o    = idx_q;
  assign csn_o    = csn_q;
  assign busy_o   = (st_q != S_IDLE);
  assign done_o   = done_q;
  assign failed_o = failed_q;
  assign ign_o    = ign_q;

  // R14: completion is reported only once the phase has left busy.
  p_done_idle_r14: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_o);
  p_busy_fall_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_q);
  // R12: a request during a run is flagged on the next cycle.
  p_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && |req_i) |=> ign_q);
  // R8: chip-select held low while words of a step are shifting.
  p_csn_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_XMIT) |-> !csn_q);
  // R10: an aborted phase always closes with a failure.
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_GAP && abort_q && cnt_q == '0) |=> (done_q && failed_q));

endmodule

// File: rtl/panel_seq_top.sv
module panel_seq_top
  import panel_seq_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int CYC_PER_US = 50,
  parameter int PAUSE_US   = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_prepare,
  input  logic start_enable,
  input  logic start_disable,
  input  logic start_unprepare,
  input  logic link_err,
  output logic spi_csn,
  output logic spi_sclk,
  output logic spi_sdo,
  output logic busy,
  output logic done,
  output logic seq_failed,
  output logic start_ignored
);

  localparam int GAP_CYC   = 4 * HALF_DIV;
  localparam int PAUSE_RAW = CYC_PER_US * PAUSE_US;
  localparam int PAUSE_CYC = (PAUSE_RAW > GAP_CYC) ? PAUSE_RAW : GAP_CYC;
  localparam int DSW       = $clog2(GAP_CYC + 1);

  step_t              step;
  logic [STEP_AW-1:0] idx;
  logic               go;
  logic [WORD_W-1:0]  word;
  logic               fin;

  panel_seq_rom u_rom (
    .idx_i  (idx),
    .step_o (step)
  );

  panel_seq_ctrl #(
    .GAP_CYC   (GAP_CYC),
    .PAUSE_CYC (PAUSE_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      ({start_unprepare, start_disable, start_enable, start_prepare}),
    .link_err_i (link_err),
    .step_i     (step),
    .fin_i      (fin),
    .idx_o      (idx),
    .go_o       (go),
    .word_o     (word),
    .csn_o      (spi_csn),
    .busy_o     (busy),
    .done_o     (done),
    .failed_o   (seq_failed),
    .ign_o      (start_ignored)
  );

  panel_seq_shift #(
    .HALF_DIV (HALF_DIV),
    .WORD_W   (WORD_W)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (go),
    .word_i (word),
    .sclk_o (spi_sclk),
    .sdo_o  (spi_sdo),
    .fin_o  (fin)
  );

  // Deselect-interval monitor, saturating at the minimum gap.
  logic [DSW-1:0] desel_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          desel_q <= DSW'(GAP_CYC);
    else if (!spi_csn)                   desel_q <= '0;
    else if (desel_q != DSW'(GAP_CYC))   desel_q <= desel_q + DSW'(1);
  end

  // R3: no clock activity while deselected.
  p_desel_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_csn |-> spi_sclk);
  // R8: minimum deselect before each new step.
  p_gap_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_csn) |-> (desel_q >= DSW'(GAP_CYC)));

endmodule

// File: tb/panel_seq_top_tb_top.sv
module panel_seq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 1;
  localparam int CPUS       = 2;
  localparam int PUS        = 3;
  localparam int GAP_MIN    = 4 * HALF;
  localparam int PAUSE_MIN  = CPUS * PUS;

  logic clk, rst_n;
  logic sp, se, sd, su;
  logic link_err;
  logic spi_csn, spi_sclk, spi_sdo, busy, done, seq_failed, start_ignored;

  panel_seq_top #(.HALF_DIV(HALF), .CYC_PER_US(CPUS), .PAUSE_US(PUS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .start_prepare(sp), .start_enable(se), .start_disable(sd),
    .start_unprepare(su), .link_err(link_err),
    .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_sdo(spi_sdo),
    .busy(busy), .done(done), .seq_failed(seq_failed),
    .start_ignored(start_ignored)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected stream entries: [10]=pause after step, [9]=closes step, [8:0]=word
  logic [10:0] exp_q[$];
  string cur_req = "R5";
  int    err_at  = -1;
  int    ent_idx = -1;
  int    p_upto  = 99;
  int    pk      = 0;

  task automatic add(input logic [7:0] c, input int n, input logic [15:0] v,
                     input bit p);
    exp_q.push_back({p, (n == 0), 1'b0, c});
    if (n == 2) begin
      exp_q.push_back({p, 1'b0, 1'b1, v[15:8]});
      exp_q.push_back({p, 1'b1, 1'b1, v[7:0]});
    end else if (n == 1) begin
      exp_q.push_back({p, 1'b1, 1'b1, v[7:0]});
    end
  endtask

  task automatic ap(input logic [7:0] c, input int n, input logic [15:0] v);
    if (pk <= p_upto) add(c, n, v, (pk < 3));
    pk++;
  endtask

  task automatic push_prepare(input int upto);
    p_upto = upto; pk = 0;
    ap(8'h00,0,0); ap(8'h00,0,0); ap(8'h00,0,0);
    ap(8'hB0,1,16'h17); ap(8'hBC,1,16'h80); ap(8'h3B,1,16'h00);
    ap(8'hB0,1,16'h16); ap(8'hB8,2,16'hFFF9); ap(8'h11,0,0);
    ap(8'hBA,1,16'h01); ap(8'hBB,1,16'h00); ap(8'h3A,1,16'h60);
    ap(8'hBF,1,16'h10); ap(8'hB1,1,16'h56); ap(8'hB2,1,16'h33);
    ap(8'hB3,1,16'h11); ap(8'hB3,1,16'h11); ap(8'hB4,1,16'h02);
    ap(8'hB5,1,16'h2B); ap(8'hB6,1,16'h40); ap(8'hB7,1,16'h03);
    ap(8'hB9,1,16'h04); ap(8'hBD,1,16'h04); ap(8'hBE,1,16'h00);
    ap(8'hC0,1,16'h11); ap(8'hC1,1,16'h11); ap(8'hC2,1,16'h11);
    ap(8'hC3,2,16'h2040); ap(8'hC4,2,16'h60C0); ap(8'hC5,2,16'h1020);
    ap(8'hC6,2,16'h60C0); ap(8'hC7,2,16'h5533); ap(8'hC8,1,16'h00);
    ap(8'hC9,1,16'h00); ap(8'hCA,1,16'h00); ap(8'hEC,2,16'h01F0);
    ap(8'hCF,1,16'h02); ap(8'hD0,2,16'h0804); ap(8'hD1,1,16'h01);
    ap(8'hD2,2,16'h0000); ap(8'hD3,2,16'h0D0E); ap(8'hD4,2,16'h11A4);
    ap(8'hD5,1,16'h0E);
  endtask

  task automatic push_unprepare();
    add(8'hB8, 2, 16'h8002, 1'b0);
    add(8'h10, 0, 16'h0, 1'b0);
    add(8'hB0, 1, 16'h00, 1'b0);
  endtask

  // Link monitor: decodes the serial stream on every clock.
  logic       prev_sclk, prev_csn, prev_sdo, closed;
  logic [8:0] shreg;
  int         nbits, gap_cnt, need_gap;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sclk = 1'b1; prev_csn = 1'b1; prev_sdo = 1'b0; closed = 1'b1;
      shreg = '0; nbits = 0; gap_cnt = 1000; need_gap = 0;
      link_err = 1'b0;
    end else begin
      chk(!(spi_csn && !spi_sclk), "R3", "sclk low while deselected", spi_sclk, 1);
      if (spi_csn && !prev_csn) begin
        chk(nbits == 0 && closed, "R8", "step cut short", nbits, 0);
        link_err = 1'b0;
        gap_cnt = 0;
      end
      if (spi_csn) gap_cnt++;
      if (!spi_csn && prev_csn) begin
        chk(gap_cnt >= need_gap, "R8 R9", "deselect interval", gap_cnt, need_gap);
        closed = 1'b0;
        ent_idx++;
        if (ent_idx == err_at) link_err = 1'b1;
      end
      if (!spi_csn && spi_sclk && !prev_sclk) begin
        chk(spi_sdo == prev_sdo, "R3", "data moved at rising edge", spi_sdo, prev_sdo);
        shreg = {shreg[7:0], spi_sdo};
        nbits++;
        if (nbits == 9) begin
          nbits = 0;
          if (exp_q.size() == 0) begin
            chk(1'b0, cur_req, "unexpected word", shreg, 0);
          end else begin
            logic [10:0] e;
            e = exp_q.pop_front();
            chk(shreg == e[8:0], {"R2 R4 ", cur_req}, "word", shreg, e[8:0]);
            closed   = e[9];
            need_gap = e[10] ? PAUSE_MIN : GAP_MIN;
          end
        end
      end
      prev_sclk = spi_sclk; prev_csn = spi_csn; prev_sdo = spi_sdo;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic fire(input logic [3:0] r);
    @(negedge clk);
    {su, sd, se, sp} = r;
    @(negedge clk);
    {su, sd, se, sp} = 4'b0;
    chk(busy == 1'b1, "R14", "busy after start", busy, 1);
  endtask

  task automatic wait_done(input bit exp_fail, input string req);
    int w = 0;
    do begin
      @(negedge clk);
      w++;
    end while (!done && w < 20000);
    chk(done == 1'b1, "R14", "done pulse", done, 1);
    chk(busy == 1'b0, "R14", "busy low at done", busy, 0);
    chk(seq_failed == exp_fail, req, "failed flag", seq_failed, exp_fail);
    chk(exp_q.size() == 0, cur_req, "words left unsent", exp_q.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, "R14", "done one cycle", done, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    {su, sd, se, sp} = 4'b0;
    repeat (3) @(negedge clk);
    chk(spi_csn && spi_sclk, "R1", "link idle in reset", {spi_csn, spi_sclk}, 3);
    chk(!busy && !done && !seq_failed && !start_ignored, "R1", "flags in reset",
        {busy, done, seq_failed, start_ignored}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(spi_csn && spi_sclk && !busy, "R1", "idle after reset",
        {spi_csn, spi_sclk, busy}, 6);

    // Full power-up with pauses after the three leading codes.
    cur_req = "R5 R9"; ent_idx = -1; err_at = -1;
    push_prepare(99);
    fire(4'b0001);
    wait_done(1'b0, "R5");

    cur_req = "R6"; ent_idx = -1;
    add(8'h29, 0, 0, 1'b0);
    fire(4'b0010);
    wait_done(1'b0, "R6");

    add(8'h28, 0, 0, 1'b0);
    fire(4'b0100);
    wait_done(1'b0, "R6");

    cur_req = "R7"; ent_idx = -1;
    push_unprepare();
    fire(4'b1000);
    wait_done(1'b0, "R7");

    // Start request during a run is ignored.
    cur_req = "R12 R5"; ent_idx = -1;
    push_prepare(99);
    fire(4'b0001);
    repeat (30) @(negedge clk);
    se = 1'b1;
    @(negedge clk);
    se = 1'b0;
    chk(start_ignored == 1'b1, "R12", "ignored flag", start_ignored, 1);
    @(negedge clk);
    chk(start_ignored == 1'b0, "R12", "ignored flag one cycle", start_ignored, 0);
    wait_done(1'b0, "R12");

    // Several starts at once: display-on wins over off and power-down.
    cur_req = "R13"; ent_idx = -1;
    add(8'h29, 0, 0, 1'b0);
    fire(4'b1110);
    wait_done(1'b0, "R13");
    cur_req = "R13"; ent_idx = -1;
    push_prepare(99);
    fire(4'b1001);
    wait_done(1'b0, "R13");

    // Error during power-up at step 5 stops the phase there.
    cur_req = "R10"; ent_idx = -1; err_at = 5;
    push_prepare(5);
    fire(4'b0001);
    wait_done(1'b1, "R10");
    repeat (4) @(negedge clk);
    chk(spi_csn == 1'b1 && !busy, "R10", "no further step", spi_csn, 1);

    // Error during power-down: all steps still go out.
    cur_req = "R11 R7"; ent_idx = -1; err_at = 0;
    push_unprepare();
    fire(4'b1000);
    wait_done(1'b1, "R11");

    // Error on display-on is reported.
    cur_req = "R10 R6"; ent_idx = -1; err_at = 0;
    add(8'h29, 0, 0, 1'b0);
    fire(4'b0010);
    wait_done(1'b1, "R10");

    // Clean phase clears the failure.
    cur_req = "R11 R6"; ent_idx = -1; err_at = -1;
    add(8'h28, 0, 0, 1'b0);
    fire(4'b0100);
    wait_done(1'b0, "R11");

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule